// File: doc/BRIEF.md
# Instruction Sequencer with Conditional Skip

This block is the fetch-and-control engine of a small 16-bit register machine. On a single-step request it reads one instruction word from a word-addressed memory, splits it into a 4-bit opcode and two 6-bit operand codes, fetches any immediate words those operands need, and then resolves the instruction. Operand values come from an external operand unit and results from an external ALU, both through combinational request/response signals. The sequencer itself owns the program counter, the stack pointer, the conditional-skip flag and the halt state.

A test instruction that fails arms the skip flag, and the next basic instruction is then discarded. The discarded instruction still moves PC past its own immediate words, so the instruction stream stays aligned. The extended group (opcode zero) supplies a subroutine call that pushes a return address. Any other extended sub-opcode stops the machine.

Top module: `isq_sequencer`

## Requirements
- R1: An instruction word is decoded as opcode = bits [3:0], first operand code = bits [9:4], second operand code = bits [15:10]. The opcode is presented on alu_op_o, and the operand codes on opa_code_o / opb_code_o and, for write-back, on wb_code_o.
- R2: After reset, pc_o = 0, sp_o = 0, halt_o = 0, busy_o = 0 and the skip flag is clear.
- R3: A step_i pulse seen while idle and not halted starts one instruction. busy_o is high for exactly 4 cycles (fetch, first immediate, second immediate, execute), starting the cycle after the pulse. step_i has no effect while busy.
- R4: Fetching the instruction adds 1 to PC. Operand codes 0x10–0x17, 0x1E and 0x1F each take one immediate word: the first operand's word is read at the instruction address + 1, and the second operand's word follows it. PC then moves past every immediate word used.
- R5: Opcodes 0x1–0xB write alu_res_i back to the first operand. A wb_req_o pulse is issued for first-operand codes 0x00–0x1A, 0x1D and 0x1E. Codes 0x1F and 0x20–0x3F are literals and take no write.
- R6: Opcodes 0xC–0xF never write. When alu_cond_i is low at execute, the skip flag is set.
- R7: With the skip flag set, the next basic instruction (opcode ≠ 0) is discarded: it issues no write-back and no memory write. PC still advances past its immediates, and the flag is cleared.
- R8: An extended instruction (opcode 0) executes even with the skip flag set, and leaves the flag set for the next basic instruction.
- R9: Extended sub-opcode 0x01 (first operand field) is a call. SP is decremented, the address following the call's immediates is written to memory at the new SP, and PC is loaded with the second operand's value.
- R10: Extended sub-opcode 0x00 or any sub-opcode other than 0x01 sets halt_o. halt_o stays high until reset, and step_i is then ignored.
- R11: A write-back to code 0x1C replaces PC and discards the pending immediate offset. A write-back to code 0x1B loads SP. Reading code 0x1C gives the address following the instruction's immediates, and reading code 0x1B gives SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Start one instruction |
| busy_o | output | 1 | Instruction in progress |
| halt_o | output | 1 | Machine stopped on an illegal extended opcode |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, same cycle as address |
| opa_code_o | output | 6 | First operand code |
| opa_imm_o | output | 16 | First operand immediate word |
| opa_val_i | input | 16 | First operand value from operand unit |
| opb_code_o | output | 6 | Second operand code |
| opb_imm_o | output | 16 | Second operand immediate word |
| opb_val_i | input | 16 | Second operand value from operand unit |
| alu_op_o | output | 4 | Opcode to the ALU |
| alu_a_o | output | 16 | First ALU input |
| alu_b_o | output | 16 | Second ALU input |
| alu_res_i | input | 16 | ALU result |
| alu_cond_i | input | 1 | ALU condition true |
| wb_req_o | output | 1 | Write-back to operand unit |
| wb_code_o | output | 6 | Write-back destination code |
| wb_imm_o | output | 16 | Write-back destination immediate |
| wb_data_o | output | 16 | Write-back data |

## Verification
Several properties are checked on every cycle: the PC increment at fetch, the silence of discarded and test instructions, the stack decrement on a call, the stickiness of halt, and the start of busy after a step. Other behaviour can only be shown by the directed scenarios, because it depends on what the machine did earlier: how far PC moves for each immediate pattern, the skip flag surviving an extended call, a PC write dropping the offset, and the exact return address stored.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned OFF_W  = 2;

  localparam logic [OP_W-1:0]   OP_EXT    = 4'h0;
  localparam logic [OP_W-1:0]   OP_TEST0  = 4'hC;
  localparam logic [CODE_W-1:0] SUB_CALL  = 6'h01;
  localparam logic [CODE_W-1:0] CODE_SP   = 6'h1B;
  localparam logic [CODE_W-1:0] CODE_PC   = 6'h1C;
  localparam logic [CODE_W-1:0] CODE_OVF  = 6'h1D;
  localparam logic [CODE_W-1:0] CODE_IND  = 6'h1E;
  localparam logic [CODE_W-1:0] CODE_LIT  = 6'h1F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_IMMA, ST_IMMB, ST_EXEC
  } isq_state_e;

  function automatic logic takes_imm(input logic [CODE_W-1:0] code);
    return (code[5:3] == 3'b010) || (code == CODE_IND) || (code == CODE_LIT);
  endfunction
endpackage

// File: rtl/isq_decode.sv
module isq_decode
  import isq_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output logic [OP_W-1:0]   op_o,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              need_a_o,
  output logic              need_b_o,
  output logic              is_ext_o,
  output logic              is_test_o,
  output logic              dst_pc_o,
  output logic              dst_sp_o,
  output logic              dst_ext_o
);
  always_comb begin
    op_o      = instr_i[3:0];
    code_a_o  = instr_i[9:4];
    code_b_o  = instr_i[15:10];
    is_ext_o  = (op_o == OP_EXT);
    is_test_o = (op_o >= OP_TEST0);
    need_a_o  = !is_ext_o && takes_imm(code_a_o);
    need_b_o  = takes_imm(code_b_o);
    dst_pc_o  = (code_a_o == CODE_PC);
    dst_sp_o  = (code_a_o == CODE_SP);
    dst_ext_o = (code_a_o < CODE_SP) || (code_a_o == CODE_OVF) || (code_a_o == CODE_IND);
  end
endmodule

// File: rtl/isq_opmux.sv
module isq_opmux
  import isq_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [WORD_W-1:0] ext_val_i,
  input  logic [WORD_W-1:0] pc_next_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic [WORD_W-1:0] val_o
);
  always_comb begin
    if (code_i == CODE_PC)      val_o = pc_next_i;
    else if (code_i == CODE_SP) val_o = sp_i;
    else                        val_o = ext_val_i;
  end
endmodule

// File: rtl/isq_sequencer.sv
module isq_sequencer
  import isq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic              busy_o,
  output logic              halt_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [CODE_W-1:0] opa_code_o,
  output logic [WORD_W-1:0] opa_imm_o,
  input  logic [WORD_W-1:0] opa_val_i,
  output logic [CODE_W-1:0] opb_code_o,
  output logic [WORD_W-1:0] opb_imm_o,
  input  logic [WORD_W-1:0] opb_val_i,
  output logic [OP_W-1:0]   alu_op_o,
  output logic [WORD_W-1:0] alu_a_o,
  output logic [WORD_W-1:0] alu_b_o,
  input  logic [WORD_W-1:0] alu_res_i,
  input  logic              alu_cond_i,
  output logic              wb_req_o,
  output logic [CODE_W-1:0] wb_code_o,
  output logic [WORD_W-1:0] wb_imm_o,
  output logic [WORD_W-1:0] wb_data_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  isq_state_e        state_q, state_d;
  logic [WORD_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [WORD_W-1:0] instr_q, instr_d, imma_q, imma_d, immb_q, immb_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              skip_q, skip_d, halt_q, halt_d;

  logic [OP_W-1:0]   op;
  logic [CODE_W-1:0] code_a, code_b;
  logic need_a, need_b, is_ext, is_test, dst_pc, dst_sp, dst_ext;
  logic [WORD_W-1:0] pc_after, val_a, val_b;

  isq_decode u_dec (
    .instr_i(instr_q), .op_o(op), .code_a_o(code_a), .code_b_o(code_b),
    .need_a_o(need_a), .need_b_o(need_b), .is_ext_o(is_ext), .is_test_o(is_test),
    .dst_pc_o(dst_pc), .dst_sp_o(dst_sp), .dst_ext_o(dst_ext)
  );

  assign pc_after = pc_q + {{(WORD_W-OFF_W){1'b0}}, off_q};

  isq_opmux u_mux_a (.code_i(code_a), .ext_val_i(opa_val_i), .pc_next_i(pc_after),
                     .sp_i(sp_q), .val_o(val_a));
  isq_opmux u_mux_b (.code_i(code_b), .ext_val_i(opb_val_i), .pc_next_i(pc_after),
                     .sp_i(sp_q), .val_o(val_b));

  // next-state process
  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    sp_d        = sp_q;
    instr_d     = instr_q;
    imma_d      = imma_q;
    immb_d      = immb_q;
    off_d       = off_q;
    skip_d      = skip_q;
    halt_d      = halt_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pc_q;
    mem_wdata_o = '0;
    wb_req_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (step_i && !halt_q) state_d = ST_FETCH;
      ST_FETCH: begin
        mem_req_o = 1'b1;
        instr_d   = mem_rdata_i;
        pc_d      = pc_q + 1'b1;
        off_d     = '0;
        imma_d    = '0;
        immb_d    = '0;
        state_d   = ST_IMMA;
      end
      ST_IMMA: begin
        if (need_a) begin
          mem_req_o = 1'b1;
          imma_d    = mem_rdata_i;
          off_d     = off_q + 1'b1;
        end
        state_d = ST_IMMB;
      end
      ST_IMMB: begin
        mem_addr_o = pc_after;
        if (need_b) begin
          mem_req_o = 1'b1;
          immb_d    = mem_rdata_i;
          off_d     = off_q + 1'b1;
        end
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        pc_d    = pc_after;
        if (is_ext) begin
          if (code_a == SUB_CALL) begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = sp_q - 1'b1;
            mem_wdata_o = pc_after;
            sp_d        = sp_q - 1'b1;
            pc_d        = val_b;
          end else begin
            halt_d = 1'b1;
          end
        end else if (skip_q) begin
          skip_d = 1'b0;
        end else if (is_test) begin
          skip_d = !alu_cond_i;
        end else if (dst_pc) begin
          pc_d = alu_res_i;
        end else if (dst_sp) begin
          sp_d = alu_res_i;
        end else if (dst_ext) begin
          wb_req_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      sp_q    <= '0;
      instr_q <= '0;
      imma_q  <= '0;
      immb_q  <= '0;
      off_q   <= '0;
      skip_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else if (rst_ok) begin
      state_q <= state_d;
      pc_q    <= pc_d;
      sp_q    <= sp_d;
      instr_q <= instr_d;
      imma_q  <= imma_d;
      immb_q  <= immb_d;
      off_q   <= off_d;
      skip_q  <= skip_d;
      halt_q  <= halt_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign halt_o     = halt_q;
  assign pc_o       = pc_q;
  assign sp_o       = sp_q;
  assign opa_code_o = code_a;
  assign opa_imm_o  = imma_q;
  assign opb_code_o = code_b;
  assign opb_imm_o  = immb_q;
  assign alu_op_o   = op;
  assign alu_a_o    = val_a;
  assign alu_b_o    = val_b;
  assign wb_code_o  = code_a;
  assign wb_imm_o   = imma_q;
  assign wb_data_o  = alu_res_i;

  // R4: the fetch cycle moves PC forward by one word
  p_fetch_advance_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + 16'd1));
  // R6: test opcodes never request a write
  p_test_silent_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_EXEC && op >= OP_TEST0) |-> !wb_req_o);
  // R7: a discarded instruction stays silent
  p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_EXEC && skip_q && op != OP_EXT) |-> (!wb_req_o && !mem_we_o));
  // R9: a call lowers SP by one
  p_call_push_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_q == ST_EXEC && op == OP_EXT && code_a == SUB_CALL) |=> (sp_q == $past(sp_q) - 16'd1));
  // R10: halt holds once raised
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    halt_o |=> halt_o);
  // R3: an accepted step makes the block busy next cycle
  p_step_start_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy_o && step_i && !halt_o) |=> busy_o);
endmodule

// File: tb/isq_sequencer_bench.sv
`timescale 1ns/100ps
module isq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        busy, halt, mem_req, mem_we, wb_req, alu_cond;
  logic [15:0] pc, sp, mem_addr, mem_wdata, mem_rdata;
  logic [5:0]  opa_code, opb_code, wb_code;
  logic [15:0] opa_imm, opb_imm, opa_val, opb_val, alu_a, alu_b, alu_res, wb_imm, wb_data;
  logic [3:0]  alu_op;

  logic [15:0] mem [0:255];
  logic [15:0] rf  [0:7];
  int          wb_cnt = 0;
  logic [5:0]  last_code;
  logic [15:0] last_imm;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  isq_sequencer u_isq_sequencer (
    .clk(clk), .rst_n(rst_n), .step_i(step), .busy_o(busy), .halt_o(halt),
    .pc_o(pc), .sp_o(sp), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .opa_code_o(opa_code), .opa_imm_o(opa_imm), .opa_val_i(opa_val),
    .opb_code_o(opb_code), .opb_imm_o(opb_imm), .opb_val_i(opb_val),
    .alu_op_o(alu_op), .alu_a_o(alu_a), .alu_b_o(alu_b), .alu_res_i(alu_res),
    .alu_cond_i(alu_cond), .wb_req_o(wb_req), .wb_code_o(wb_code),
    .wb_imm_o(wb_imm), .wb_data_o(wb_data)
  );

  // environment models: memory, operand unit, ALU
  assign mem_rdata = mem[mem_addr[7:0]];

  function automatic logic [15:0] opnd(input logic [5:0] c, input logic [15:0] imm);
    if (c < 6'h08)       return rf[c[2:0]];
    else if (c == 6'h1E) return mem[imm[7:0]];
    else if (c == 6'h1F) return imm;
    else if (c >= 6'h20) return {10'd0, c - 6'h20};
    else                 return 16'd0;
  endfunction

  assign opa_val = opnd(opa_code, opa_imm);
  assign opb_val = opnd(opb_code, opb_imm);

  always_comb begin
    alu_res  = 16'd0;
    alu_cond = 1'b0;
    case (alu_op)
      4'h1: alu_res = alu_b;
      4'h2: alu_res = alu_a + alu_b;
      4'h3: alu_res = alu_a - alu_b;
      4'h9: alu_res = alu_a & alu_b;
      4'hA: alu_res = alu_a | alu_b;
      4'hB: alu_res = alu_a ^ alu_b;
      4'hC: alu_cond = (alu_a == alu_b);
      4'hD: alu_cond = (alu_a != alu_b);
      4'hE: alu_cond = (alu_a > alu_b);
      4'hF: alu_cond = ((alu_a & alu_b) != 0);
      default: ;
    endcase
  end

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (wb_req) begin
      wb_cnt    <= wb_cnt + 1;
      last_code <= wb_code;
      last_imm  <= wb_imm;
      if (wb_code < 6'h08)       rf[wb_code[2:0]] <= wb_data;
      else if (wb_code == 6'h1E) mem[wb_imm[7:0]] <= wb_data;
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [5:0] a, input logic [5:0] b);
    return {b, a, op};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // step held for 'hold' cycles; returns number of busy cycles
  task automatic run(input int hold, output int busy_cycles);
    int cyc = 0;
    @(negedge clk);
    step = 1'b1;
    repeat (hold) @(negedge clk);
    step = 1'b0;
    while (busy && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
    busy_cycles = (cyc > 0) ? cyc + hold - 1 : 0;
  endtask

  task automatic t_reset();
    chk("R2", "pc", pc, 16'h0);
    chk("R2", "sp", sp, 16'h0);
    chk("R2", "halt", {15'd0, halt}, 16'h0);
    chk("R2", "busy", {15'd0, busy}, 16'h0);
  endtask

  task automatic t_set_imm();
    int n;
    mem[0] = enc(4'h1, 6'h00, 6'h1F); mem[1] = 16'h1234;
    run(1, n);
    chk("R3", "busy cycles", 16'(n), 16'd4);
    chk("R1", "wb code", {10'd0, last_code}, 16'h0);
    chk("R5", "reg0", rf[0], 16'h1234);
    chk("R4", "pc one imm", pc, 16'h2);
  endtask

  task automatic t_add_two_imm();
    int n;
    mem[2] = enc(4'h2, 6'h1E, 6'h1F); mem[3] = 16'h0050; mem[4] = 16'h0007;
    mem[8'h50] = 16'h0005;
    run(1, n);
    chk("R4", "pc two imm", pc, 16'h5);
    chk("R4", "first imm", last_imm, 16'h0050);
    chk("R5", "mem sum", mem[8'h50], 16'h000C);
  endtask

  task automatic t_skip_basic();
    int n, w;
    rf[1] = 16'h0AAA;
    mem[5] = enc(4'hC, 6'h00, 6'h21);
    run(1, n);
    w = wb_cnt;
    chk("R6", "test no write", 16'(wb_cnt), 16'(w));
    mem[6] = enc(4'h1, 6'h01, 6'h1F); mem[7] = 16'hBEEF;
    run(1, n);
    chk("R7", "discard reg1", rf[1], 16'h0AAA);
    chk("R7", "discard wb count", 16'(wb_cnt), 16'(w));
    chk("R7", "discard pc", pc, 16'h8);
    mem[8] = enc(4'h1, 6'h02, 6'h23);
    run(1, n);
    chk("R7", "flag cleared", rf[2], 16'h0003);
  endtask

  task automatic t_test_pass();
    int n;
    mem[9]  = enc(4'hD, 6'h00, 6'h21);
    mem[10] = enc(4'h1, 6'h03, 6'h24);
    run(1, n); run(1, n);
    chk("R6", "true test no skip", rf[3], 16'h0004);
    chk("R4", "pc literals", pc, 16'd11);
  endtask

  task automatic t_sp_call();
    int n, w;
    w = wb_cnt;
    mem[11] = enc(4'h1, 6'h1B, 6'h28);
    run(1, n);
    chk("R11", "sp write", sp, 16'h0008);
    chk("R11", "sp write no wb", 16'(wb_cnt), 16'(w));
    mem[12] = enc(4'h0, 6'h01, 6'h1F); mem[13] = 16'h0060;
    run(1, n);
    chk("R9", "sp after call", sp, 16'h0007);
    chk("R9", "return addr", mem[7], 16'd14);
    chk("R9", "pc target", pc, 16'h0060);
  endtask

  task automatic t_skip_ext();
    int n;
    mem[8'h60] = enc(4'hE, 6'h21, 6'h22);
    mem[8'h61] = enc(4'h0, 6'h01, 6'h1F); mem[8'h62] = 16'h0070;
    mem[8'h70] = enc(4'h1, 6'h04, 6'h25);
    mem[8'h71] = enc(4'h1, 6'h04, 6'h26);
    run(1, n); run(1, n);
    chk("R8", "call under skip pc", pc, 16'h0070);
    chk("R8", "call under skip ret", mem[6], 16'h0063);
    run(1, n);
    chk("R8", "flag kept reg4", rf[4], 16'h0000);
    chk("R8", "flag kept pc", pc, 16'h0071);
    run(1, n);
    chk("R7", "after discard reg4", rf[4], 16'h0006);
  endtask

  task automatic t_pc_rw();
    int n;
    mem[8'h72] = enc(4'h1, 6'h1C, 6'h1F); mem[8'h73] = 16'h0090;
    run(1, n);
    chk("R11", "pc write drops offset", pc, 16'h0090);
    mem[8'h90] = enc(4'h1, 6'h05, 6'h1C);
    run(1, n);
    chk("R11", "pc read", rf[5], 16'h0091);
  endtask

  task automatic t_literal_dst();
    int n, w;
    w = wb_cnt;
    mem[8'h91] = enc(4'h1, 6'h22, 6'h1F); mem[8'h92] = 16'h5555;
    run(1, n);
    chk("R5", "literal dst no wb", 16'(wb_cnt), 16'(w));
    chk("R5", "literal dst pc", pc, 16'h0093);
  endtask

  task automatic t_step_held();
    int n;
    mem[8'h93] = enc(4'h2, 6'h05, 6'h21);
    run(2, n);
    chk("R3", "held step busy", 16'(n), 16'd4);
    chk("R3", "held step one instr pc", pc, 16'h0094);
    chk("R3", "held step reg5", rf[5], 16'h0092);
  endtask

  task automatic t_halt();
    int n;
    mem[8'h94] = enc(4'h0, 6'h02, 6'h20);
    run(1, n);
    chk("R10", "halt raised", {15'd0, halt}, 16'h1);
    chk("R10", "halt pc", pc, 16'h0095);
    run(1, n);
    chk("R10", "step ignored busy", 16'(n), 16'd0);
    chk("R10", "step ignored pc", pc, 16'h0095);
    chk("R10", "halt stays", {15'd0, halt}, 16'h1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    for (int i = 0; i < 8; i++) rf[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set_imm();
    t_add_two_imm();
    t_skip_basic();
    t_test_pass();
    t_sp_call();
    t_skip_ext();
    t_pc_rw();
    t_literal_dst();
    t_step_held();
    t_halt();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule